// File: doc/BRIEF.md
# Sampling Delay Tuning Search Engine

This block picks a receive sampling delay for a high-speed SD/MMC data path without software stepping through every setting. On a start pulse it drives a 7-bit delay tap and, for each candidate setting, asks an external test port to run one tuning-block read of 64 bytes. The port answers with a single-cycle done pulse that carries a pass/fail bit, and only one test is outstanding at a time.

The search has two phases. The first climbs from tap 0 until a setting passes, which gives the lower edge of the good window. The second climbs from the tap above that edge while settings keep passing; the first failing tap, less one, is the upper edge. The engine then moves to the truncated midpoint of the two edges, runs one confirmation test there, and ends with a one-cycle completion pulse and a result flag. While a search runs, three clock-path control outputs are held high: a tuning-in-progress flag, a tuned-clock select and a feedback-clock select. The tuning-in-progress flag drops once the search ends; the two selects stay set. The delay is also presented as a 16-bit control word with the tap in bits 14:8.

The controller has nine states. IDLE waits for a start. P1_LAUNCH and P1_WAIT issue a lower-edge probe and take its answer. P2_LAUNCH and P2_WAIT do the same for the upper edge. MID_LOAD moves the tap to the midpoint. VFY_LAUNCH and VFY_WAIT run the confirmation test, and FINISH raises the completion pulse. The transitions are as follows. IDLE moves to P1_LAUNCH on start. A LAUNCH state always moves to its WAIT state. P1_WAIT returns to P1_LAUNCH on a fail below tap 126, moves to P2_LAUNCH on a pass below 126, and moves to MID_LOAD after tap 126 is answered. P2_WAIT returns to P2_LAUNCH on a pass below 126 and moves to MID_LOAD on a fail or after tap 126. MID_LOAD moves to VFY_LAUNCH, VFY_WAIT moves to FINISH on the answer, and FINISH returns to IDLE.

Top module: `tap_tuner`

## Requirements
- R1: After reset, test_req, tune_done, tune_ok, exec_tune, smp_sel and fb_sel are 0 and tap_word is 0.
- R2: Phase one probes taps 0, 1, 2, ... in order, each once, and stops at the first passing tap, which becomes the lower edge. If taps 0 to 126 all fail, both edges become 127 and tap 127 is not probed in phase one.
- R3: Phase two probes taps upward from the lower edge plus 1, each once. The first failing tap F makes the upper edge F-1, and no further phase-two probe follows.
- R4: If phase two passes through tap 126, or the lower edge is 126, the upper edge becomes 127 without probing 127. The upper edge is never below the lower edge.
- R5: After the search, exactly one confirmation probe runs at floor((lower+upper)/2). tune_done then pulses for one cycle with tune_ok equal to that probe's pass bit, and the tap stays at the midpoint.
- R6: exec_tune, smp_sel and fb_sel are 1 from the cycle after the start pulse is taken, through the tune_done cycle. exec_tune is 0 in the cycle after tune_done. smp_sel and fb_sel stay 1 until reset.
- R7: tap_word carries the current tap in bits 14:8 and zero in every other bit. The tap does not change while a probe is outstanding.
- R8: test_req is a one-cycle pulse, and no new test_req is issued until test_done for the previous one has been taken.
- R9: test_blk_len reads 64, the byte count of each tuning read.
- R10: A start pulse that arrives while a search is running has no effect on the probe sequence or the result.
- R11: When no tap passes in phase one, the confirmation probe runs at tap 127, and tune_ok reports that probe's own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tune_go | input | 1 | Start pulse for a search, taken only in IDLE |
| test_done | input | 1 | One-cycle answer from the test port |
| test_pass | input | 1 | Pass bit, valid with test_done |
| test_req | output | 1 | One-cycle request to run one tuning read |
| test_blk_len | output | 7 | Bytes per tuning read (64) |
| tap_word | output | 16 | Tune control word, tap in bits 14:8 |
| exec_tune | output | 1 | Search in progress |
| smp_sel | output | 1 | Tuned sampling-clock select |
| fb_sel | output | 1 | Feedback-clock select |
| tune_done | output | 1 | One-cycle completion pulse |
| tune_ok | output | 1 | Result of the confirmation probe |

## Verification
The assertions assume that the test port raises test_done for exactly one cycle, only while a probe is outstanding, and at least one cycle after test_req. They also assume that test_pass is read only together with test_done and that tune_go is a pulse. The bench's responding port keeps to this. It answers a request only after a latency counter of one to three cycles has run down, and it drops done and pass at the next falling edge. The pass/fail answer comes from a contiguous window that is chosen for each run, or from an empty window, so the search edges, the clamping at 127 and the case where nothing passes are all reached.

// File: rtl/tuner_pkg.sv
package tuner_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_P1_LAUNCH,
        ST_P1_WAIT,
        ST_P2_LAUNCH,
        ST_P2_WAIT,
        ST_MID_LOAD,
        ST_VFY_LAUNCH,
        ST_VFY_WAIT,
        ST_FINISH
    } tune_state_e;

endpackage

// File: rtl/tuner_probe.sv
module tuner_probe (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic test_done,
    input  logic test_pass,
    output logic test_req,
    output logic pending,
    output logic res_valid,
    output logic res_pass
);

    assign test_req  = launch & ~pending;
    assign res_valid = test_done & pending;
    assign res_pass  = test_pass;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (test_req) begin
            pending <= 1'b1;
        end else if (test_done) begin
            pending <= 1'b0;
        end
    end

    AST_DONE_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        test_done |-> pending); // R8
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        test_req |=> !test_req); // R8

endmodule

// File: rtl/tuner_window.sv
module tuner_window #(
    parameter int TAP_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             min_we,
    input  logic [TAP_W-1:0] min_val,
    input  logic             max_we,
    input  logic [TAP_W-1:0] max_val,
    output logic [TAP_W-1:0] win_min,
    output logic [TAP_W-1:0] win_max,
    output logic [TAP_W-1:0] win_mid
);

    localparam int SUM_W = TAP_W + 1;

    logic [SUM_W-1:0] edge_sum;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_min <= '0;
            win_max <= '0;
        end else if (clr) begin
            win_min <= '0;
            win_max <= '0;
        end else begin
            if (min_we) win_min <= min_val;
            if (max_we) win_max <= max_val;
        end
    end

    always_comb begin
        edge_sum = SUM_W'(win_min) + SUM_W'(win_max);
        win_mid  = edge_sum[SUM_W-1:1];
    end

endmodule

// File: rtl/tuner_fsm.sv
module tuner_fsm
    import tuner_pkg::*;
#(
    parameter int TAP_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             res_valid,
    input  logic             res_pass,
    input  logic [TAP_W-1:0] win_min,
    input  logic [TAP_W-1:0] win_max,
    input  logic [TAP_W-1:0] win_mid,
    output logic             launch,
    output logic             win_clr,
    output logic             min_we,
    output logic [TAP_W-1:0] min_val,
    output logic             max_we,
    output logic [TAP_W-1:0] max_val,
    output logic [TAP_W-1:0] tap,
    output logic             busy,
    output logic             clk_sel,
    output logic             done,
    output logic             ok
);

    localparam logic [TAP_W-1:0] TAP_MAX   = {TAP_W{1'b1}};
    localparam logic [TAP_W-1:0] LAST_TEST = TAP_MAX - TAP_W'(1);
    localparam logic [TAP_W-1:0] TAP_ONE   = TAP_W'(1);

    tune_state_e      state, nxt;
    logic [TAP_W-1:0] tap_nxt;
    logic             ok_nxt;
    logic             sel_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            tap     <= '0;
            ok      <= 1'b0;
            clk_sel <= 1'b0;
        end else begin
            state   <= nxt;
            tap     <= tap_nxt;
            ok      <= ok_nxt;
            clk_sel <= sel_nxt;
        end
    end

    always_comb begin
        nxt     = state;
        tap_nxt = tap;
        ok_nxt  = ok;
        sel_nxt = clk_sel;
        win_clr = 1'b0;
        min_we  = 1'b0;
        min_val = tap;
        max_we  = 1'b0;
        max_val = tap - TAP_ONE;
        unique case (state)
            ST_IDLE: begin
                if (go) begin
                    tap_nxt = '0;
                    ok_nxt  = 1'b0;
                    sel_nxt = 1'b1;
                    win_clr = 1'b1;
                    nxt     = ST_P1_LAUNCH;
                end
            end
            ST_P1_LAUNCH: nxt = ST_P1_WAIT;
            ST_P1_WAIT: begin
                if (res_valid) begin
                    if (res_pass) begin
                        min_we  = 1'b1;
                        min_val = tap;
                        if (tap == LAST_TEST) begin
                            max_we  = 1'b1;
                            max_val = TAP_MAX;
                            nxt     = ST_MID_LOAD;
                        end else begin
                            tap_nxt = tap + TAP_ONE;
                            nxt     = ST_P2_LAUNCH;
                        end
                    end else if (tap == LAST_TEST) begin
                        min_we  = 1'b1;
                        min_val = TAP_MAX;
                        max_we  = 1'b1;
                        max_val = TAP_MAX;
                        nxt     = ST_MID_LOAD;
                    end else begin
                        tap_nxt = tap + TAP_ONE;
                        nxt     = ST_P1_LAUNCH;
                    end
                end
            end
            ST_P2_LAUNCH: nxt = ST_P2_WAIT;
            ST_P2_WAIT: begin
                if (res_valid) begin
                    if (!res_pass) begin
                        max_we  = 1'b1;
                        max_val = tap - TAP_ONE;
                        nxt     = ST_MID_LOAD;
                    end else if (tap == LAST_TEST) begin
                        max_we  = 1'b1;
                        max_val = TAP_MAX;
                        nxt     = ST_MID_LOAD;
                    end else begin
                        tap_nxt = tap + TAP_ONE;
                        nxt     = ST_P2_LAUNCH;
                    end
                end
            end
            ST_MID_LOAD: begin
                tap_nxt = win_mid;
                nxt     = ST_VFY_LAUNCH;
            end
            ST_VFY_LAUNCH: nxt = ST_VFY_WAIT;
            ST_VFY_WAIT: begin
                if (res_valid) begin
                    ok_nxt = res_pass;
                    nxt    = ST_FINISH;
                end
            end
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        launch = (state == ST_P1_LAUNCH) || (state == ST_P2_LAUNCH) ||
                 (state == ST_VFY_LAUNCH);
        busy   = (state != ST_IDLE);
        done   = (state == ST_FINISH);
    end

    AST_P1_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_P1_LAUNCH && $past(state) == ST_P1_WAIT) |-> tap == $past(tap) + TAP_ONE); // R2
    AST_TAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_P1_WAIT || state == ST_P2_WAIT || state == ST_VFY_WAIT) |-> $stable(tap)); // R7
    AST_WINDOW_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_VFY_LAUNCH) |-> win_max >= win_min); // R4
    AST_MID_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_VFY_LAUNCH) |-> tap == win_mid); // R5
    AST_EXEC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R6
    AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R10

endmodule

// File: rtl/tap_tuner.sv
module tap_tuner #(
    parameter int TAP_W     = 7,
    parameter int WORD_W    = 16,
    parameter int TAP_SHIFT = 8,
    parameter int BLK_BYTES = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           tune_go,
    input  logic                           test_done,
    input  logic                           test_pass,
    output logic                           test_req,
    output logic [$clog2(BLK_BYTES+1)-1:0] test_blk_len,
    output logic [WORD_W-1:0]              tap_word,
    output logic                           exec_tune,
    output logic                           smp_sel,
    output logic                           fb_sel,
    output logic                           tune_done,
    output logic                           tune_ok
);

    localparam int LEN_W = $clog2(BLK_BYTES + 1);

    logic             launch, pending, res_valid, res_pass;
    logic             win_clr, min_we, max_we, clk_sel;
    logic [TAP_W-1:0] min_val, max_val, win_min, win_max, win_mid, tap;

    tuner_probe u_probe (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .test_done (test_done),
        .test_pass (test_pass),
        .test_req  (test_req),
        .pending   (pending),
        .res_valid (res_valid),
        .res_pass  (res_pass)
    );

    tuner_window #(.TAP_W(TAP_W)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (win_clr),
        .min_we  (min_we),
        .min_val (min_val),
        .max_we  (max_we),
        .max_val (max_val),
        .win_min (win_min),
        .win_max (win_max),
        .win_mid (win_mid)
    );

    tuner_fsm #(.TAP_W(TAP_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (tune_go),
        .res_valid (res_valid),
        .res_pass  (res_pass),
        .win_min   (win_min),
        .win_max   (win_max),
        .win_mid   (win_mid),
        .launch    (launch),
        .win_clr   (win_clr),
        .min_we    (min_we),
        .min_val   (min_val),
        .max_we    (max_we),
        .max_val   (max_val),
        .tap       (tap),
        .busy      (exec_tune),
        .clk_sel   (clk_sel),
        .done      (tune_done),
        .ok        (tune_ok)
    );

    assign smp_sel      = clk_sel;
    assign fb_sel       = clk_sel;
    assign test_blk_len = LEN_W'(BLK_BYTES);
    assign tap_word     = WORD_W'(tap) << TAP_SHIFT;

    AST_REQ_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        test_req |-> (exec_tune && smp_sel && fb_sel)); // R6
    AST_REQ_IDLE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !test_done) |=> !test_req); // R8

endmodule

// File: tb/test_tap_tuner.sv
module test_tap_tuner;

    logic        clk = 1'b0;
    logic        rst_n, tune_go, test_done, test_pass;
    logic        test_req, exec_tune, smp_sel, fb_sel, tune_done, tune_ok;
    logic [6:0]  test_blk_len;
    logic [15:0] tap_word;

    always #2 clk = ~clk;

    tap_tuner i_tap_tuner (
        .clk          (clk),
        .rst_n        (rst_n),
        .tune_go      (tune_go),
        .test_done    (test_done),
        .test_pass    (test_pass),
        .test_req     (test_req),
        .test_blk_len (test_blk_len),
        .tap_word     (tap_word),
        .exec_tune    (exec_tune),
        .smp_sel      (smp_sel),
        .fb_sel       (fb_sel),
        .tune_done    (tune_done),
        .tune_ok      (tune_ok)
    );

    int vec_n = 0;
    int err_n = 0;
    int exp_q[$];
    int cur_lo = 1000, cur_hi = -1, cur_lat = 1;

    function automatic bit passes(int t);
        return (t >= cur_lo) && (t <= cur_hi);
    endfunction

    task automatic check(bit cond, string req, int act, int exp);
        vec_n++;
        if (!cond) begin
            err_n++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor + responding test port: pops expected taps as requests appear
    initial begin
        int cnt;
        int held;
        cnt = 0;
        held = 0;
        test_done = 1'b0;
        test_pass = 1'b0;
        forever begin
            @(negedge clk);
            test_done = 1'b0;
            test_pass = 1'b0;
            if (cnt > 0) begin
                check(!test_req, "R8 request while outstanding", test_req, 0);
                cnt--;
                if (cnt == 0) begin
                    test_done = 1'b1;
                    test_pass = passes(held);
                end
            end else if (rst_n && test_req) begin
                int t;
                t = int'(tap_word[14:8]);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 R3 unexpected probe", t, -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(t == e, "R2 R3 R5 probe tap order", t, e);
                end
                check(tap_word == (16'(t) << 8), "R7 tap word layout", int'(tap_word), t << 8);
                check(test_blk_len == 7'd64, "R9 block length", int'(test_blk_len), 64);
                check(exec_tune && smp_sel && fb_sel, "R6 control bits during probe",
                      int'({exec_tune, smp_sel, fb_sel}), 7);
                held = t;
                cnt = cur_lat;
            end
        end
    end

    task automatic run(int lo, int hi, int lat, bit poke);
        int  mn, mx, mid, c, guard;
        bit  found, exp_ok;
        cur_lo = lo;
        cur_hi = hi;
        cur_lat = lat;
        exp_q.delete();
        found = 1'b0;
        mn = 127;
        mx = 127;
        for (int t = 0; t <= 126; t++) begin
            exp_q.push_back(t);
            if (passes(t)) begin
                mn = t;
                found = 1'b1;
                break;
            end
        end
        if (found) begin
            mx = 127;
            for (int t = mn + 1; t <= 126; t++) begin
                exp_q.push_back(t);
                if (!passes(t)) begin
                    mx = t - 1;
                    break;
                end
            end
        end
        mid = (mn + mx) / 2;
        exp_q.push_back(mid);
        exp_ok = passes(mid);

        @(negedge clk);
        tune_go = 1'b1;
        @(negedge clk);
        tune_go = 1'b0;
        check(exec_tune && smp_sel && fb_sel, "R6 control bits after start",
              int'({exec_tune, smp_sel, fb_sel}), 7);
        guard = 0;
        while (!tune_done && guard < 20000) begin
            tune_go = (poke && guard == 30);   // R10 start during a run
            @(negedge clk);
            guard++;
        end
        tune_go = 1'b0;
        check(tune_done, "R5 completion watchdog", guard, 20000);
        check(int'(tap_word[14:8]) == mid, "R5 R11 final tap", int'(tap_word[14:8]), mid);
        check(tune_ok == exp_ok, "R5 R11 result flag", tune_ok, exp_ok);
        check(exp_q.size() == 0, "R2 R3 R4 probes left over", exp_q.size(), 0);
        @(negedge clk);
        check(!tune_done, "R5 done is a single pulse", tune_done, 0);
        check(!exec_tune, "R6 exec_tune drops after done", exec_tune, 0);
        check(smp_sel && fb_sel, "R6 selects stay set", int'({smp_sel, fb_sel}), 3);
        check(int'(tap_word[14:8]) == mid, "R7 tap held at midpoint", int'(tap_word[14:8]), mid);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        tune_go = 1'b0;
        repeat (3) @(negedge clk);
        check(!test_req && !tune_done && !tune_ok, "R1 reset handshake outputs",
              int'({test_req, tune_done, tune_ok}), 0);
        check(!exec_tune && !smp_sel && !fb_sel, "R1 reset control bits",
              int'({exec_tune, smp_sel, fb_sel}), 0);
        check(tap_word == 16'd0, "R1 reset tap word", int'(tap_word), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run(10, 20, 1, 1'b0);    // R2 R3 ordinary window
        run(0, 127, 2, 1'b0);    // R4 passes through 126
        run(5, 5, 1, 1'b0);      // R3 single-tap window
        run(126, 127, 3, 1'b0);  // R4 lower edge at 126
        run(1000, -1, 1, 1'b0);  // R11 nothing passes
        run(127, 127, 2, 1'b0);  // R11 verify at 127 passes
        run(40, 60, 2, 1'b1);    // R10 start pulse mid-run ignored

        $display("== %0d vectors applied, %0d miscompares ==", vec_n, err_n);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        err_n++;
        $display("FAIL watchdog run did not end actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", vec_n, err_n);
        $finish;
    end

endmodule